// File: doc/BRIEF.md
# Drift-Corrected Scheduler Delta Generator

The block times the basic step of a time-aware egress scheduler, called a delta. A delta is nominally 25 oscillator ticks (200 ns at 125 MHz). A network-synchronized clock runs off the same oscillator, and a servo may speed it up or slow it down. The block models that clock with a fixed-point increment applied on every oscillator tick. Over each correction period, whose length is counted in synchronized-clock ticks, it measures how many ticks the synchronized clock gained on, or lost to, the oscillator.

When a period closes, the measured drift is added to a signed backlog. Every following delta is shortened by the positive part of the backlog, or lengthened by the negative part, one whole tick at a time. The change per delta is capped by a slew limit, and whatever exceeds the cap stays in the backlog for later deltas. The scheduler therefore stays phase-aligned to the synchronized clock, and a delta lasts 200 ns only on average.

The block follows frequency adjustments made while it runs. A step of the synchronized clock must be handled by dropping `run` and raising it again. The correction period is meant to be a whole multiple of the schedule cycle, usually the longest one. The block also reports the current delta index within a schedule cycle.

Top module: `sdg_delta_gen`

## Requirements
- R1: During and just after reset, `delta_strobe` is 0 and `cycle_pos` is 0.
- R2: With `sync_inc` equal to 256 (1.0 with 8 fraction bits) and a tick on every cycle, `delta_strobe` pulses once after the 25th tick counted from `run` rising, and again after every further 25 ticks.
- R3: Only cycles with `osc_tick` high advance the delta and the synchronized clock. With a tick on every other cycle, strobes are 50 cycles apart.
- R4: `cycle_pos` increments on each delta end and returns to 0 after reaching `cycle_len`-1. It changes in the same cycle that `delta_strobe` rises.
- R5: Each tick advances the synchronized clock by `sync_inc`/256 ticks, and the fraction is kept. A correction period closes on the tick where the synchronized ticks reach `corr_period`, and any excess counts toward the next period. The drift of a period is its synchronized ticks minus its oscillator ticks, and it is added to the backlog on that same tick.
- R6: The length of each delta is fixed when the delta starts: 25 minus the clamped backlog. The clamped amount is then removed from the backlog. A positive backlog shortens deltas.
- R7: A negative backlog, from a synchronized clock slower than the oscillator, lengthens deltas.
- R8: The correction per delta is limited to SLEW_MAX = 5 ticks, so every delta is 20 to 30 ticks long. A backlog beyond the limit is carried into later deltas until it is used up, and deltas then return to 25 ticks.
- R9: While `run` is low, no strobe is produced and `cycle_pos` is held at 0. The phase, period count, drift and backlog are cleared, so the first delta after a restart is 25 ticks long.
- R10: `delta_strobe` is high for exactly one cycle per delta.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | High to run the scheduler timebase; low stops it and clears it |
| osc_tick | input | 1 | Oscillator tick enable |
| sync_inc | input | INC_W (10) | Synchronized-clock advance per tick, unsigned, FRAC_W (8) fraction bits |
| corr_period | input | PER_W (16) | Correction period length in synchronized-clock ticks, at least 4 |
| cycle_len | input | POS_W (8) | Deltas per schedule cycle |
| delta_strobe | output | 1 | One-cycle pulse at the end of each delta |
| cycle_pos | output | POS_W (8) | Delta index within the schedule cycle |

## Verification
The bench keeps the default parameters: a nominal delta of 25 ticks, a slew limit of 5, and 8 fraction bits on the increment. With these, an increment of 512 or 128 gives a drift of exactly plus or minus one tick per oscillator tick, or per two ticks. Correction periods of 4 to 14 ticks then close several times within one delta, so the bench can predict every strobe tick by hand. Changing the rate after a single period closes leaves a backlog of known size, and the bench watches it drain across the slew cap. A schedule cycle of 3 deltas makes the position wrap within a few deltas.

// File: rtl/sdg_pkg.sv
package sdg_pkg;

   // Bits needed to hold values 0..v
   function automatic int sdg_bits_for(input int v);
      int b;
      b = 1;
      while ((1 << b) <= v) b++;
      return b;
   endfunction

   localparam int SDG_NOM_TICKS_DEF = 25;
   localparam int SDG_SLEW_MAX_DEF  = 5;
   localparam int SDG_FRAC_W_DEF    = 8;

endpackage

// File: rtl/sdg_sync_tracker.sv
module sdg_sync_tracker #(
   parameter int FRAC_W = 8,
   parameter int INC_W  = 10,
   parameter int PER_W  = 16,
   parameter int ACC_W  = 20
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    run,
   input  logic                    osc_tick,
   input  logic [INC_W-1:0]        sync_inc,
   input  logic [PER_W-1:0]        corr_period,
   output logic                    period_close,
   output logic signed [ACC_W-1:0] period_drift
);
   localparam int SUM_W   = INC_W + 1;
   localparam int CARRY_W = SUM_W - FRAC_W;

   logic [FRAC_W-1:0]        frac_q;
   logic [PER_W-1:0]         per_q;
   logic signed [ACC_W-1:0]  drift_q;
   logic [SUM_W-1:0]         sum;
   logic [CARRY_W-1:0]       carry;
   logic [PER_W:0]           per_sum;
   logic signed [ACC_W-1:0]  step;

   always_comb begin
      sum          = {1'b0, sync_inc} + SUM_W'(frac_q);
      carry        = sum[SUM_W-1:FRAC_W];
      step         = ACC_W'(carry) - ACC_W'(1);
      per_sum      = {1'b0, per_q} + (PER_W+1)'(carry);
      period_close = run && osc_tick && (per_sum >= {1'b0, corr_period});
      period_drift = drift_q + step;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frac_q  <= '0;
         per_q   <= '0;
         drift_q <= '0;
      end else if (!run) begin
         frac_q  <= '0;
         per_q   <= '0;
         drift_q <= '0;
      end else if (osc_tick) begin
         frac_q <= sum[FRAC_W-1:0];
         if (period_close) begin
            per_q   <= PER_W'(per_sum - {1'b0, corr_period});
            drift_q <= '0;
         end else begin
            per_q   <= per_sum[PER_W-1:0];
            drift_q <= period_drift;
         end
      end
   end

   // R9: a restart begins from a cleared synchronized-clock measurement
   a_r9_restart_clean: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run) |-> (drift_q == '0 && per_q == '0 && frac_q == '0));

   // R5: while the clock idles between ticks the measurement holds
   a_r5_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
      run && !osc_tick |=> run |-> ($stable(drift_q) && $stable(per_q)));

endmodule

// File: rtl/sdg_slew_bank.sv
module sdg_slew_bank #(
   parameter int ACC_W    = 20,
   parameter int SLEW_MAX = 5,
   parameter int ADJ_W    = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    run,
   input  logic                    period_close,
   input  logic signed [ACC_W-1:0] period_drift,
   input  logic                    take,
   output logic signed [ADJ_W-1:0] adj
);
   localparam logic signed [ACC_W-1:0] LIM_P = ACC_W'(SLEW_MAX);
   localparam logic signed [ACC_W-1:0] LIM_N = -LIM_P;

   logic signed [ACC_W-1:0] pend_q;
   logic signed [ACC_W-1:0] adj_wide;
   logic signed [ACC_W-1:0] add_term;
   logic signed [ACC_W-1:0] sub_term;

   generate
      if (SLEW_MAX == 0) begin : g_no_slew
         assign adj_wide = '0;
      end else begin : g_clamp
         always_comb begin
            if (pend_q > LIM_P)      adj_wide = LIM_P;
            else if (pend_q < LIM_N) adj_wide = LIM_N;
            else                     adj_wide = pend_q;
         end
      end
   endgenerate

   assign adj      = adj_wide[ADJ_W-1:0];
   assign add_term = period_close ? period_drift : '0;
   assign sub_term = take ? adj_wide : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pend_q <= '0;
      else if (!run) pend_q <= '0;
      else           pend_q <= pend_q + add_term - sub_term;
   end

   // R8: a backlog above the limit loses exactly the limit per delta
   a_r8_remainder_kept: assert property (@(posedge clk) disable iff (!rst_n)
      run && take && !period_close && pend_q > LIM_P |=>
         run |-> (pend_q == $past(pend_q) - LIM_P));

   // R9: the backlog is empty while stopped
   a_r9_backlog_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> pend_q == '0);

endmodule

// File: rtl/sdg_delta_timer.sv
module sdg_delta_timer #(
   parameter int NOM_TICKS = 25,
   parameter int SLEW_MAX  = 5,
   parameter int POS_W     = 8,
   parameter int ADJ_W     = 4,
   parameter int LEN_W     = 5
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    run,
   input  logic                    osc_tick,
   input  logic signed [ADJ_W-1:0] adj,
   input  logic [POS_W-1:0]        cycle_len,
   output logic                    delta_end,
   output logic                    delta_strobe,
   output logic [POS_W-1:0]        cycle_pos
);
   logic [LEN_W-1:0] tick_q;
   logic [LEN_W-1:0] len_q;
   logic [LEN_W-1:0] next_len;
   logic [POS_W-1:0] next_pos;

   always_comb begin
      delta_end = run && osc_tick && (tick_q == len_q - LEN_W'(1));
      next_len  = LEN_W'(NOM_TICKS) - LEN_W'(adj);
      next_pos  = (cycle_pos == cycle_len - POS_W'(1)) ? '0 : cycle_pos + POS_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick_q       <= '0;
         len_q        <= LEN_W'(NOM_TICKS);
         cycle_pos    <= '0;
         delta_strobe <= 1'b0;
      end else if (!run) begin
         tick_q       <= '0;
         len_q        <= LEN_W'(NOM_TICKS);
         cycle_pos    <= '0;
         delta_strobe <= 1'b0;
      end else begin
         delta_strobe <= delta_end;
         if (osc_tick) begin
            if (delta_end) begin
               tick_q    <= '0;
               len_q     <= next_len;
               cycle_pos <= next_pos;
            end else begin
               tick_q <= tick_q + LEN_W'(1);
            end
         end
      end
   end

   // R8: every delta stays inside the slew window
   a_r8_len_window: assert property (@(posedge clk) disable iff (!rst_n)
      (len_q >= LEN_W'(NOM_TICKS - SLEW_MAX)) && (len_q <= LEN_W'(NOM_TICKS + SLEW_MAX)));

   // R10: strobe lasts one cycle
   a_r10_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      delta_strobe |=> !delta_strobe);

   // R9: silent and parked while stopped
   a_r9_silent_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (!delta_strobe && cycle_pos == '0));

   // R3: no tick, no new strobe
   a_r3_tick_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !osc_tick |=> !delta_strobe);

   // R4: position wraps to zero exactly after the last index
   a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(delta_strobe) && $stable(cycle_len) |->
         ((cycle_pos == '0) == ($past(cycle_pos) == cycle_len - POS_W'(1))));

endmodule

// File: rtl/sdg_delta_gen.sv
module sdg_delta_gen
   import sdg_pkg::*;
#(
   parameter int NOM_TICKS = SDG_NOM_TICKS_DEF,
   parameter int SLEW_MAX  = SDG_SLEW_MAX_DEF,
   parameter int FRAC_W    = SDG_FRAC_W_DEF,
   parameter int INC_W     = 10,
   parameter int PER_W     = 16,
   parameter int ACC_W     = 20,
   parameter int POS_W     = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             osc_tick,
   input  logic [INC_W-1:0] sync_inc,
   input  logic [PER_W-1:0] corr_period,
   input  logic [POS_W-1:0] cycle_len,
   output logic             delta_strobe,
   output logic [POS_W-1:0] cycle_pos
);
   localparam int LEN_W = sdg_bits_for(NOM_TICKS + SLEW_MAX);
   localparam int ADJ_W = sdg_bits_for(SLEW_MAX) + 1;

   generate
      if (NOM_TICKS < 2 * SLEW_MAX + 2) begin : g_bad_slew
         $error("sdg_delta_gen: NOM_TICKS too small for SLEW_MAX");
      end
      if (INC_W <= FRAC_W) begin : g_bad_inc
         $error("sdg_delta_gen: INC_W must exceed FRAC_W");
      end
      if (ACC_W <= PER_W) begin : g_bad_acc
         $error("sdg_delta_gen: ACC_W must exceed PER_W");
      end
   endgenerate

   logic                    period_close;
   logic signed [ACC_W-1:0] period_drift;
   logic                    delta_end;
   logic signed [ADJ_W-1:0] adj;

   sdg_sync_tracker #(
      .FRAC_W (FRAC_W),
      .INC_W  (INC_W),
      .PER_W  (PER_W),
      .ACC_W  (ACC_W)
   ) u_track (
      .clk          (clk),
      .rst_n        (rst_n),
      .run          (run),
      .osc_tick     (osc_tick),
      .sync_inc     (sync_inc),
      .corr_period  (corr_period),
      .period_close (period_close),
      .period_drift (period_drift)
   );

   sdg_slew_bank #(
      .ACC_W    (ACC_W),
      .SLEW_MAX (SLEW_MAX),
      .ADJ_W    (ADJ_W)
   ) u_bank (
      .clk          (clk),
      .rst_n        (rst_n),
      .run          (run),
      .period_close (period_close),
      .period_drift (period_drift),
      .take         (delta_end),
      .adj          (adj)
   );

   sdg_delta_timer #(
      .NOM_TICKS (NOM_TICKS),
      .SLEW_MAX  (SLEW_MAX),
      .POS_W     (POS_W),
      .ADJ_W     (ADJ_W),
      .LEN_W     (LEN_W)
   ) u_timer (
      .clk          (clk),
      .rst_n        (rst_n),
      .run          (run),
      .osc_tick     (osc_tick),
      .adj          (adj),
      .cycle_len    (cycle_len),
      .delta_end    (delta_end),
      .delta_strobe (delta_strobe),
      .cycle_pos    (cycle_pos)
   );

   // R1: outputs quiet right after reset
   a_r1_reset_quiet: assert property (@(posedge clk)
      $rose(rst_n) |-> (!delta_strobe && cycle_pos == '0));

endmodule

// File: tb/sdg_delta_gen_bench.sv
module sdg_delta_gen_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       run = 1'b0;
   logic       osc_tick = 1'b0;
   logic [9:0] sync_inc = 10'd256;
   logic [15:0] corr_period = 16'd256;
   logic [7:0] cycle_len = 8'd3;
   logic       delta_strobe;
   logic [7:0] cycle_pos;

   int n_chk = 0;
   int n_bad = 0;
   int ecount = 0;
   int start = 0;
   int got [0:3];
   int npos;

   always #10 clk = ~clk;
   always @(posedge clk) ecount <= ecount + 1;

   sdg_delta_gen u_sdg_delta_gen (
      .clk(clk), .rst_n(rst_n), .run(run), .osc_tick(osc_tick),
      .sync_inc(sync_inc), .corr_period(corr_period), .cycle_len(cycle_len),
      .delta_strobe(delta_strobe), .cycle_pos(cycle_pos)
   );

   typedef struct packed {
      int inc1; int sw; int inc2; int per;
      int e0; int e1; int e2; int e3;
   } vec_t;

   // R2 nominal; R6/R8 fast; R7/R8 slow; R8 drain; R7 small slow backlog
   localparam vec_t VECS [0:4] = '{
      '{256, 0, 256, 256, 25, 50, 75, 100},
      '{512, 0, 512,  10, 25, 45, 65,  85},
      '{128, 0, 128,   4, 25, 55, 85, 115},
      '{512, 7, 256,  14, 25, 45, 68,  93},
      '{128, 8, 256,   4, 25, 54, 79, 104}
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic stop_for(input int n);
      @(negedge clk);
      run = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   // start run at a negedge, collect up to 4 strobe ticks relative to start
   task automatic collect(input int inc1, input int sw, input int inc2,
                          input int per, input bit alt, input string req);
      int k;
      run = 1'b1;
      osc_tick = 1'b1;
      sync_inc = 10'(inc1);
      corr_period = 16'(per);
      start = ecount;
      npos = 0;
      for (int c = 0; c < 400 && npos < 4; c++) begin
         @(negedge clk);
         k = ecount - start;
         if (delta_strobe) begin
            got[npos] = k;
            npos++;
            chk(cycle_pos == 8'(npos % 3), "R4", cycle_pos, npos % 3);
         end
         if (k == sw) sync_inc = 10'(inc2);
         if (alt) osc_tick = ~osc_tick;
      end
      chk(npos == 4, req, npos, 4);
   endtask

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(delta_strobe == 1'b0, "R1", delta_strobe, 0);
      chk(cycle_pos == 8'd0, "R1", cycle_pos, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(delta_strobe == 1'b0 && cycle_pos == 8'd0, "R1", cycle_pos, 0);

      // vector table walk (R2, R5, R6, R7, R8, R9 via restart per vector)
      for (int v = 0; v < 5; v++) begin
         stop_for(3);
         collect(VECS[v].inc1, VECS[v].sw, VECS[v].inc2, VECS[v].per, 1'b0, "R5");
         chk(got[0] == VECS[v].e0, (v == 0) ? "R2" : "R9", got[0], VECS[v].e0);
         chk(got[1] == VECS[v].e1, (v == 2 || v == 4) ? "R7" : "R6", got[1], VECS[v].e1);
         chk(got[2] == VECS[v].e2, "R8", got[2], VECS[v].e2);
         chk(got[3] == VECS[v].e3, "R8", got[3], VECS[v].e3);
      end

      // R3: tick on every other cycle, strobe one cycle wide (R10)
      stop_for(3);
      collect(256, 0, 256, 256, 1'b1, "R3");
      chk(got[0] == 49, "R3", got[0], 49);
      chk(got[1] == 99, "R3", got[1], 99);
      chk(got[1] - got[0] == 50, "R10", got[1] - got[0], 50);

      // R10: strobe drops on the next cycle
      stop_for(3);
      run = 1'b1; osc_tick = 1'b1; sync_inc = 10'd256; corr_period = 16'd256;
      start = ecount;
      while (ecount - start < 25) @(negedge clk);
      chk(delta_strobe == 1'b1, "R10", delta_strobe, 1);
      @(negedge clk);
      chk(delta_strobe == 1'b0, "R10", delta_strobe, 0);

      // R9: stop with a large backlog, stay silent, restart clean
      stop_for(3);
      run = 1'b1; osc_tick = 1'b1; sync_inc = 10'd512; corr_period = 16'd10;
      start = ecount;
      while (ecount - start < 60) @(negedge clk);
      run = 1'b0;
      begin
         int seen;
         seen = 0;
         for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            if (delta_strobe || cycle_pos != 8'd0) seen++;
         end
         chk(seen == 0, "R9", seen, 0);
      end
      collect(256, 0, 256, 256, 1'b0, "R9");
      chk(got[0] == 25, "R9", got[0], 25);
      chk(got[1] == 50, "R9", got[1], 50);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   // watchdog
   initial begin
      #(20 * 150000);
      n_bad++;
      n_chk++;
      $display("FAIL R2 watchdog: cycles %0d expected < %0d", ecount, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule